// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer

This block is a 16-bit up-counter with one 8-bit control register and a 16-bit capture/reload register pair. It has three working modes and a stopped state. In capture mode, a falling edge on an external trigger pin can take a snapshot of the running count. In auto-reload mode, the count restarts from a preset value on overflow, and the trigger can force that restart early. In baud-generator mode, the counter runs at the undivided oscillator tick, reloads on every overflow and sends a one-clock pulse to a serial port. The serial port itself lies outside this block.

Software writes and reads five byte-wide registers through a simple port. Hardware sets two sticky flags, one for overflow and one for the trigger, and only software clears them. The interrupt request is active while either flag is set. The counting source can be the oscillator tick divided by a parameter (12 by default), or the falling edges of an external count pin. Both external pins pass through a two-flop synchronizer before their edges are detected.

Top module: `cr_timer16`

## Requirements
- R1: After a synchronous reset, the control register, the counter and the capture pair all read 0x00. `irq`, `ovf_flag`, `ext_flag` and `baud_tick` are all low.
- R2: While the run bit (control bit 2) is 0, the counter does not increment.
- R3: When control bit 1 is 0, the counter increments once per OSC_DIV pulses of `osc_tick`. When control bit 1 is 1, the counter increments once per falling edge of `cnt_pin`. A falling edge is detected after the pin passes the two-flop synchronizer.
- R4: Capture mode is selected when bits 5 and 4 are 0 and bit 0 is 1. In this mode an overflow from 0xFFFF wraps the counter to 0x0000 and sets the overflow flag (bit 7). A falling edge on `trig_pin` has an effect only when the enable bit (bit 3) is 1. It then copies the counter into the capture pair and sets the external flag (bit 6).
- R5: Auto-reload mode is selected when bits 5, 4 and 0 are all 0. In this mode an overflow loads the counter from the capture/reload pair and sets the overflow flag. When bit 3 is 1, a falling edge on `trig_pin` also loads the counter from the pair and sets the external flag.
- R6: Baud-generator mode is selected when bit 5 or bit 4 is 1. In this mode, with bit 1 at 0, the counter increments on every `osc_tick`. It reloads from the pair on overflow whatever bit 0 holds. The overflow flag stays clear. `baud_tick` pulses high for one clock in the cycle after each overflow.
- R7: In baud-generator mode, trigger-pin edges are ignored. They cause no capture, no reload and no external flag.
- R8: Both flags stay set until software writes 0 to them. A hardware set in the same cycle as a software write wins. `irq` is high whenever either flag is set.
- R9: A software write to a counter byte in the same cycle as an increment takes priority. The written value is kept and no increment happens in that cycle.
- R10: The registers sit at these addresses: 0 for control, 1 for counter low, 2 for counter high, 3 for pair low and 4 for pair high. `rd_data` returns the addressed register combinationally and returns 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One pulse per oscillator period |
| cnt_pin | input | 1 | External count input (asynchronous) |
| trig_pin | input | 1 | External trigger input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | Trigger flag |
| baud_tick | output | 1 | One-clock pulse per overflow in baud-generator mode |

## Verification
The bench counts in three ways: divided oscillator ticks, single-clock oscillator ticks in baud-generator mode, and external pin edges. This shows that each tick source drives the counter only in its own mode. Overflow is tested by preloading the counter just below 0xFFFF, once with a zero pair and once with a non-zero pair. The result tells wrap-to-zero apart from reload. Trigger edges are applied with the enable bit cleared, in capture mode, in reload mode and in baud-generator mode, so that snapshot, forced reload and suppression each leave a different trace in the registers and flags. A counter write in the same cycle as a running increment separates write priority from increment priority.

// File: rtl/cr16_pkg.sv
package cr16_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_CNT_LO = 3'd1,
        REG_CNT_HI = 3'd2,
        REG_CAP_LO = 3'd3,
        REG_CAP_HI = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic ovf;      // bit 7
        logic ext;      // bit 6
        logic rx_sel;   // bit 5
        logic tx_sel;   // bit 4
        logic ext_en;   // bit 3
        logic run;      // bit 2
        logic cnt_src;  // bit 1
        logic cap_sel;  // bit 0
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'd0,
        MODE_RELOAD  = 2'd1,
        MODE_BAUD    = 2'd2
    } mode_e;

    function automatic mode_e mode_of(input ctrl_t c);
        if (c.rx_sel || c.tx_sel) return MODE_BAUD;
        else if (c.cap_sel)       return MODE_CAPTURE;
        else                      return MODE_RELOAD;
    endfunction

    function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] word,
                                                  input int unsigned idx,
                                                  input logic [BYTE_W-1:0] b);
        logic [CNT_W-1:0] r;
        r = word;
        r[idx*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction

endpackage

// File: rtl/cr16_edge_sync.sv
module cr16_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign fall = prev && !chain[STAGES-1];

endmodule

// File: rtl/cr16_tick_div.sv
module cr16_tick_div #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic tick_out
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (tick_in) begin
            if (phase == LAST) phase <= '0;
            else               phase <= phase + 1'b1;
        end
    end

    assign tick_out = tick_in && (phase == LAST);

endmodule

// File: rtl/cr16_core.sv
module cr16_core
    import cr16_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inc,
    input  logic                 trig_fall,
    input  logic                 ctrl_we,
    input  logic                 cnt_we_lo,
    input  logic                 cnt_we_hi,
    input  logic                 cap_we_lo,
    input  logic                 cap_we_hi,
    input  logic [BYTE_W-1:0]    wdata,
    output ctrl_t                ctrl_q,
    output logic [CNT_W-1:0]     cnt_q,
    output logic [CNT_W-1:0]     cap_q,
    output logic                 baud_tick
);
    mode_e            mode;
    logic             is_baud;
    logic             cnt_wr;
    logic             wrap;
    logic             trig_evt;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cap_d;
    ctrl_t            ctrl_d;

    assign mode     = mode_of(ctrl_q);
    assign is_baud  = (mode == MODE_BAUD);
    assign cnt_wr   = cnt_we_lo || cnt_we_hi;
    assign wrap     = inc && (cnt_q == CNT_MAX) && !cnt_wr;
    assign trig_evt = trig_fall && ctrl_q.ext_en && !is_baud;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            if (cnt_we_lo) cnt_d = put_byte(cnt_d, 0, wdata);
            if (cnt_we_hi) cnt_d = put_byte(cnt_d, 1, wdata);
        end else if (wrap) begin
            cnt_d = (mode == MODE_CAPTURE) ? '0 : cap_q;
        end else if (trig_evt && mode == MODE_RELOAD) begin
            cnt_d = cap_q;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_comb begin
        cap_d = cap_q;
        if (cap_we_lo || cap_we_hi) begin
            if (cap_we_lo) cap_d = put_byte(cap_d, 0, wdata);
            if (cap_we_hi) cap_d = put_byte(cap_d, 1, wdata);
        end else if (trig_evt && mode == MODE_CAPTURE) begin
            cap_d = cnt_q;
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) ctrl_d = ctrl_t'(wdata);
        if (wrap && !is_baud) ctrl_d.ovf = 1'b1;
        if (trig_evt)         ctrl_d.ext = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            cnt_q     <= '0;
            cap_q     <= '0;
            baud_tick <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_d;
            cnt_q     <= cnt_d;
            cap_q     <= cap_d;
            baud_tick <= wrap && is_baud;
        end
    end

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !cnt_wr && !trig_evt) |=> $stable(cnt_q)); // R2

    AST_CAPTURE_SNAP: assert property (@(posedge clk) disable iff (rst)
        (trig_evt && mode == MODE_CAPTURE && !cap_we_lo && !cap_we_hi)
            |=> cap_q == $past(cnt_q)); // R4

    AST_RELOAD_OVF: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt_q == CNT_MAX && !cnt_wr && mode != MODE_CAPTURE)
            |=> cnt_q == $past(cap_q)); // R5

    AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (is_baud && !ctrl_q.ovf && !ctrl_we) |=> !ctrl_q.ovf); // R6

    AST_BAUD_NO_EXT: assert property (@(posedge clk) disable iff (rst)
        (is_baud && !ctrl_q.ext && !ctrl_we) |=> !ctrl_q.ext); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q.ovf || ctrl_q.ext) && !ctrl_we)
            |=> (ctrl_q.ovf >= $past(ctrl_q.ovf)) && (ctrl_q.ext >= $past(ctrl_q.ext))); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (cnt_we_lo && inc) |=> cnt_q[BYTE_W-1:0] == $past(wdata)); // R9

endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
    import cr16_pkg::*;
#(
    parameter int OSC_DIV     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              baud_tick
);
    logic             cnt_fall;
    logic             trig_fall;
    logic             div_tick;
    logic             inc;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic             timer_tick;

    cr16_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall)
    );

    cr16_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall)
    );

    cr16_tick_div #(.DIV(OSC_DIV)) u_div (
        .clk(clk), .rst(rst), .tick_in(osc_tick), .tick_out(div_tick)
    );

    assign timer_tick = (mode_of(ctrl_q) == MODE_BAUD) ? osc_tick : div_tick;
    assign inc        = ctrl_q.run && (ctrl_q.cnt_src ? cnt_fall : timer_tick);

    cr16_core u_core (
        .clk       (clk),
        .rst       (rst),
        .inc       (inc),
        .trig_fall (trig_fall),
        .ctrl_we   (wr_en && wr_addr == REG_CTRL),
        .cnt_we_lo (wr_en && wr_addr == REG_CNT_LO),
        .cnt_we_hi (wr_en && wr_addr == REG_CNT_HI),
        .cap_we_lo (wr_en && wr_addr == REG_CAP_LO),
        .cap_we_hi (wr_en && wr_addr == REG_CAP_HI),
        .wdata     (wr_data),
        .ctrl_q    (ctrl_q),
        .cnt_q     (cnt_q),
        .cap_q     (cap_q),
        .baud_tick (baud_tick)
    );

    always_comb begin
        case (rd_addr)
            REG_CTRL:   rd_data = ctrl_q;
            REG_CNT_LO: rd_data = cnt_q[BYTE_W-1:0];
            REG_CNT_HI: rd_data = cnt_q[CNT_W-1:BYTE_W];
            REG_CAP_LO: rd_data = cap_q[BYTE_W-1:0];
            REG_CAP_HI: rd_data = cap_q[CNT_W-1:BYTE_W];
            default:    rd_data = '0;
        endcase
    end

    assign ovf_flag = ctrl_q.ovf;
    assign ext_flag = ctrl_q.ext;
    assign irq      = ctrl_q.ovf || ctrl_q.ext;

endmodule

// File: tb/cr_timer16_tb_top.sv
module cr_timer16_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq, ovf_flag, ext_flag, baud_tick;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cr_timer16 dut_i (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
        .baud_tick(baud_tick)
    );

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; osc_tick = 1'b0; cnt_pin = 1'b1; trig_pin = 1'b1; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd16(input logic [2:0] lo_addr, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(lo_addr, lo);
        rd(lo_addr + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic pin_edge(input bit is_trig);
        @(negedge clk);
        if (is_trig) trig_pin = 1'b0; else cnt_pin = 1'b0;
        repeat (5) @(negedge clk);
        if (is_trig) trig_pin = 1'b1; else cnt_pin = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] c; logic [15:0] v;
        do_reset();
        rd(3'd0, c);    check("R1 ctrl", c, 8'h00);
        rd16(3'd1, v);  check("R1 counter", v, 16'h0000);
        rd16(3'd3, v);  check("R1 pair", v, 16'h0000);
        check("R1 outputs", {irq, ovf_flag, ext_flag, baud_tick}, 0);
    endtask

    task automatic t_timer();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 8'h04);
        @(negedge clk); osc_tick = 1'b1;
        repeat (120) @(negedge clk);
        osc_tick = 1'b0;
        rd16(3'd1, v); check("R3 divided tick count", v, 16'd10);
        wr(3'd0, 8'h00);
        @(negedge clk); osc_tick = 1'b1;
        repeat (36) @(negedge clk);
        osc_tick = 1'b0;
        rd16(3'd1, v); check("R2 stopped counter", v, 16'd10);
    endtask

    task automatic t_counter();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 8'h06);
        for (int i = 0; i < 5; i++) pin_edge(1'b0);
        rd16(3'd1, v); check("R3 pin edge count", v, 16'd5);
    endtask

    task automatic t_cap_ovf();
        logic [15:0] v;
        do_reset();
        wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h07);
        pin_edge(1'b0); pin_edge(1'b0);
        rd16(3'd1, v); check("R4 wrap to zero", v, 16'h0000);
        check("R4 ovf flag", ovf_flag, 1);
        check("R8 irq from ovf", irq, 1);
        rd16(3'd3, v); check("R4 pair untouched", v, 16'h0000);
        wr(3'd0, 8'h07);
        check("R8 sw clear", {irq, ovf_flag}, 0);
    endtask

    task automatic t_cap_trig();
        logic [15:0] v;
        do_reset();
        wr(3'd1, 8'h34); wr(3'd2, 8'h12);
        wr(3'd0, 8'h01);
        pin_edge(1'b1);
        rd16(3'd3, v); check("R4 trigger disabled", v, 16'h0000);
        check("R4 no ext when disabled", ext_flag, 0);
        wr(3'd0, 8'h09);
        pin_edge(1'b1);
        rd16(3'd3, v); check("R4 snapshot", v, 16'h1234);
        check("R4 ext flag", ext_flag, 1);
        check("R8 irq from ext", irq, 1);
        repeat (5) @(negedge clk);
        check("R8 ext sticky", ext_flag, 1);
    endtask

    task automatic t_reload();
        logic [15:0] v;
        do_reset();
        wr(3'd3, 8'hCD); wr(3'd4, 8'hAB);
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h06);
        pin_edge(1'b0);
        rd16(3'd1, v); check("R5 reload on ovf", v, 16'hABCD);
        check("R5 ovf flag", ovf_flag, 1);
        wr(3'd0, 8'h08);
        wr(3'd1, 8'h05); wr(3'd2, 8'h00);
        pin_edge(1'b1);
        rd16(3'd1, v); check("R5 trigger reload", v, 16'hABCD);
        check("R5 ext flag", ext_flag, 1);
    endtask

    task automatic t_baud();
        logic [15:0] v; logic [7:0] c;
        int pulses;
        do_reset();
        wr(3'd3, 8'hFD); wr(3'd4, 8'hFF);
        wr(3'd1, 8'hFD); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h15);
        rd(3'd0, c); check("R10 ctrl readback", c, 8'h15);
        rd(3'd7, c); check("R10 unused address", c, 8'h00);
        pulses = 0;
        osc_tick = 1'b1;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (baud_tick) pulses++;
        end
        osc_tick = 1'b0;
        check("R6 baud pulses", pulses, 3);
        rd16(3'd1, v); check("R6 reload ignores bit0", v, 16'hFFFD);
        check("R6 no ovf flag", ovf_flag, 0);
        @(negedge clk);
        check("R6 pulse ends", baud_tick, 0);
        // R9: counter-low write in an increment cycle
        osc_tick = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h40;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd1, c); check("R9 write beats increment", c, 8'h40);
        @(negedge clk);
        osc_tick = 1'b0;
        rd(3'd1, c); check("R9 counting resumes", c, 8'h41);
        // R7: trigger ignored in baud mode
        wr(3'd0, 8'h28);
        wr(3'd1, 8'h00); wr(3'd2, 8'h01);
        pin_edge(1'b1);
        rd16(3'd1, v); check("R7 no reload", v, 16'h0100);
        rd16(3'd3, v); check("R7 no capture", v, 16'hFFFD);
        check("R7 no ext flag", ext_flag, 0);
    endtask

    initial begin
        t_reset();
        t_timer();
        t_counter();
        t_cap_ovf();
        t_cap_trig();
        t_reload();
        t_baud();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule